// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Timer

This block is the digital heart of a critical-conduction flyback controller. It drives one gate-enable output. A switching cycle starts when a synchronous valley pulse reports that the transformer has demagnetised. The cycle ends when a synchronised current-comparator trip arrives. Every time limit is counted on the system clock, and each is a module parameter given in clock cycles.

During the on phase, the block masks the current trip for a leading-edge window and forces the gate off at a maximum on time. During the off phase, it masks valley pulses for a blanking window after turn-off. If no valley arrives, it starts a new cycle after a demag timeout. It always starts a new cycle once a maximum off time is reached. A minimum spacing between turn-ons caps the switching frequency, and a valley that comes too early is held until that spacing has elapsed. The protection logic drives an enable input. Dropping it stops switching at once. Raising it starts a new pulse without waiting for a valley.

Top module: `qr_cycle_timer`

## Requirements
- R1: A trip that is high while the gate has been high for fewer than LEB_CYC cycles is ignored, and the gate stays high.
- R2: A trip that is seen in on-cycle k, with k >= LEB_CYC, ends the pulse at the next clock edge, so the high time is k+1 cycles.
- R3: The gate never stays high for more than MAX_ON_CYC cycles. Without an accepted trip, the high time is exactly MAX_ON_CYC.
- R4: A valley pulse in off-cycle v, with v < BLANK_CYC, has no effect.
- R5: A valley pulse in off-cycle v, with v >= BLANK_CYC, starts the next pulse at the next edge (low time v+1) when the period limit allows it.
- R6: Without an accepted valley, the gate rises after BLANK_CYC+TOUT_CYC low cycles, provided that this is within the other limits.
- R7: The low time in a running cycle never exceeds MAX_OFF_CYC. When it reaches MAX_OFF_CYC, the gate rises.
- R8: Two consecutive turn-ons are at least MIN_PER_CYC cycles apart. An accepted valley or a timeout that comes earlier is deferred until exactly MIN_PER_CYC.
- R9: While en_i is low, gate_o is low in the same cycle and all timers are cleared. Valley and trip pulses have no effect in this state.
- R10: At the first clock edge that samples en_i high after it was low, the gate rises without any valley event.
- R11: After reset, gate_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all limits are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run permission from the protection logic |
| valley_i | input | 1 | Synchronous demagnetisation (valley) event |
| trip_i | input | 1 | Synchronous current-comparator trip |
| gate_o | output | 1 | Gate-enable output |

## Verification
The bench puts trips exactly on the last blanked on-cycle and on the first accepted one, and it puts valleys on the last masked and the first accepted off-cycle. A design with an off-by-one window would stretch or cut the measured pulse by one cycle. Early valleys after short pulses test the deferral: a design that drops the deferred valley would wait for the timeout, and one that ignores the period would turn on too early. A second instance with a timeout that is longer than the off-time clamp shows that the clamp ends the low phase. Dropping and raising enable shows whether the gate falls in the same cycle, whether stray pulses leak through, and whether the restart pulse begins with timers that were cleared.

// File: rtl/qr_timer_pkg.sv
package qr_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } qr_phase_t;

  // bits needed to hold values 0..maxv
  function automatic int cnt_bits(input int maxv);
    int b;
    b = $clog2(maxv + 1);
    return (b < 1) ? 1 : b;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // last cycle index of a window that lasts len cycles
  function automatic int last_idx(input int len);
    return (len > 0) ? len - 1 : 0;
  endfunction

endpackage

// File: rtl/qr_on_timer.sv
module qr_on_timer #(
  parameter int LEB_CYC    = 18,
  parameter int MAX_ON_CYC = 3350,
  parameter int W          = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         gate_q,
  input  logic         trip_i,
  output logic [W-1:0] cnt_o,
  output logic         trip_ok_o,
  output logic         end_o
);
  localparam logic [W-1:0] LEB_V     = W'(LEB_CYC);
  localparam logic [W-1:0] ON_LAST_V = W'(qr_timer_pkg::last_idx(MAX_ON_CYC));

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr || !gate_q)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign trip_ok_o = gate_q && trip_i && (cnt_q >= LEB_V);
  assign end_o     = gate_q && (trip_ok_o || (cnt_q == ON_LAST_V));

  // R1: inside the blanking window the pulse continues
  a_r1_leb_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !clr && cnt_q < LEB_V && cnt_q != ON_LAST_V) |=> gate_q);

  // R3: on counter never reaches the on-time limit while high
  a_r3_max_on: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (int'(cnt_q) < MAX_ON_CYC));

endmodule

// File: rtl/qr_off_timer.sv
module qr_off_timer #(
  parameter int BLANK_CYC   = 275,
  parameter int TOUT_CYC    = 400,
  parameter int MAX_OFF_CYC = 1750,
  parameter int W           = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         counting,
  input  logic         valley_i,
  input  logic         period_ok,
  output logic [W-1:0] cnt_o,
  output logic         start_o
);
  localparam logic [W-1:0] BLANK_V    = W'(BLANK_CYC);
  localparam logic [W-1:0] TOUT_LAST  = W'(qr_timer_pkg::last_idx(BLANK_CYC + TOUT_CYC));
  localparam logic [W-1:0] OFF_LAST_V = W'(qr_timer_pkg::last_idx(MAX_OFF_CYC));

  logic [W-1:0] cnt_q;
  logic         pend_q;
  logic         valley_ok, tout_hit, clamp_hit, want_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr || !counting) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign valley_ok = counting && valley_i && (cnt_q >= BLANK_V);
  assign tout_hit  = counting && (cnt_q >= TOUT_LAST);
  assign clamp_hit = counting && (cnt_q == OFF_LAST_V);
  assign want_on   = pend_q || valley_ok || tout_hit;

  // a valley accepted before the period has elapsed is remembered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (clr || !counting)         pend_q <= 1'b0;
    else if (valley_ok && !period_ok)  pend_q <= 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = counting && (clamp_hit || (want_on && period_ok));

  // R7: the off counter stays below the clamp while low
  a_r7_max_off: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (int'(cnt_q) < MAX_OFF_CYC));

  // R8: a remembered valley is only held while the period blocks it
  a_r8_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !clr && pend_q && period_ok) |-> start_o);

endmodule

// File: rtl/qr_period_guard.sv
module qr_period_guard #(
  parameter int MIN_PER_CYC = 385,
  parameter int W           = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt_o,
  output logic         ok_o
);
  localparam logic [W-1:0] PER_LAST_V = W'(qr_timer_pkg::last_idx(MIN_PER_CYC));

  logic [W-1:0] cnt_q;

  // counts cycles since the last turn-on, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (restart)              cnt_q <= '0;
    else if (cnt_q < PER_LAST_V)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ok_o  = (cnt_q >= PER_LAST_V);

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PER_LAST_V);

endmodule

// File: rtl/qr_cycle_timer.sv
module qr_cycle_timer #(
  parameter int LEB_CYC     = 18,
  parameter int MAX_ON_CYC  = 3350,
  parameter int BLANK_CYC   = 275,
  parameter int TOUT_CYC    = 400,
  parameter int MAX_OFF_CYC = 1750,
  parameter int MIN_PER_CYC = 385
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic valley_i,
  input  logic trip_i,
  output logic gate_o
);
  import qr_timer_pkg::*;

  localparam int W = cnt_bits(max4(MAX_ON_CYC, MAX_OFF_CYC, MIN_PER_CYC,
                                   BLANK_CYC + TOUT_CYC));
  localparam logic [W-1:0] BLANK_V    = W'(BLANK_CYC);
  localparam logic [W-1:0] PER_LAST_V = W'(last_idx(MIN_PER_CYC));
  localparam logic [W-1:0] OFF_LAST_V = W'(last_idx(MAX_OFF_CYC));

  qr_phase_t    phase_q, phase_d;
  logic         gate_q, off_phase, clr;
  logic         on_end, trip_ok, off_start, per_ok, going_on;
  logic [W-1:0] on_cnt, off_cnt, per_cnt;

  assign clr       = !en_i;
  assign gate_q    = (phase_q == PH_ON);
  assign off_phase = (phase_q == PH_OFF);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: phase_d = PH_ON;
      PH_ON:   if (on_end)    phase_d = PH_OFF;
      PH_OFF:  if (off_start) phase_d = PH_ON;
      default: phase_d = PH_IDLE;
    endcase
    if (!en_i) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign going_on = (phase_d == PH_ON) && !gate_q;
  assign gate_o   = gate_q && en_i;

  qr_on_timer #(
    .LEB_CYC(LEB_CYC), .MAX_ON_CYC(MAX_ON_CYC), .W(W)
  ) u_on (
    .clk(clk), .rst_n(rst_n), .clr(clr), .gate_q(gate_q), .trip_i(trip_i),
    .cnt_o(on_cnt), .trip_ok_o(trip_ok), .end_o(on_end)
  );

  qr_off_timer #(
    .BLANK_CYC(BLANK_CYC), .TOUT_CYC(TOUT_CYC), .MAX_OFF_CYC(MAX_OFF_CYC), .W(W)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .clr(clr), .counting(off_phase),
    .valley_i(valley_i), .period_ok(per_ok),
    .cnt_o(off_cnt), .start_o(off_start)
  );

  qr_period_guard #(
    .MIN_PER_CYC(MIN_PER_CYC), .W(W)
  ) u_per (
    .clk(clk), .rst_n(rst_n), .restart(going_on),
    .cnt_o(per_cnt), .ok_o(per_ok)
  );

  // R2: an accepted trip ends the pulse at the next edge
  a_r2_trip_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_ok && en_i) |=> !gate_q);

  // R3: the on counter tracks the high phase (0 in its first cycle)
  a_r3_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (on_cnt == '0));

  // R4: no turn-on inside the demag blanking window
  a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (off_phase && en_i && off_cnt < BLANK_V && off_cnt != OFF_LAST_V) |=> !gate_q);

  // R8: no turn-on before the minimum period has elapsed
  a_r8_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    (off_phase && en_i && per_cnt < PER_LAST_V && off_cnt != OFF_LAST_V) |=> !gate_q);

  // R9: enable low masks the gate in the same cycle
  a_r9_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !gate_o);

  // R10: enabling from idle starts a pulse on the next edge
  a_r10_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && en_i) |=> gate_q);

endmodule

// File: tb/qr_cycle_timer_tb.sv
module qr_cycle_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEB = 4, MAXON = 60, BLANK = 10, TOUT = 16, MAXOFF = 40, MINPER = 30;
  localparam int NONE = 255;
  localparam int NVEC = 8;
  // trip cycle, valley cycle, expected high, expected low
  localparam int VEC [NVEC][4] = '{
    '{10, 15, 11, 19},   // R2 + R8 deferred valley
    '{20, 12, 21, 13},   // R2 + R5
    '{ 2, NONE, 60, 26}, // R1 ignored, R3 max on, R6 timeout
    '{ 4,  9,  5, 26},   // R2 first accepted, R4 last masked
    '{ 4, 10,  5, 25},   // R5 first accepted but R8 deferral
    '{59, 10, 60, 11},   // R3 boundary, R5
    '{NONE, 20, 60, 21}, // R3, R5
    '{25,  3, 26, 26}    // R4 early valley, R6
  };

  logic clk = 0, rst_n = 0, en = 0, en2 = 0, valley = 0, trip = 0;
  logic gate, gate2;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qr_cycle_timer #(.LEB_CYC(LEB), .MAX_ON_CYC(MAXON), .BLANK_CYC(BLANK),
    .TOUT_CYC(TOUT), .MAX_OFF_CYC(MAXOFF), .MIN_PER_CYC(MINPER)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .valley_i(valley), .trip_i(trip), .gate_o(gate));

  // second instance: timeout longer than the off-time clamp
  qr_cycle_timer #(.LEB_CYC(LEB), .MAX_ON_CYC(MAXON), .BLANK_CYC(BLANK),
    .TOUT_CYC(50), .MAX_OFF_CYC(MAXOFF), .MIN_PER_CYC(MINPER)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .en_i(en2), .valley_i(valley), .trip_i(trip), .gate_o(gate2));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic g(input bit sel);
    return sel ? gate2 : gate;
  endfunction

  // called at a negedge where the gate is in its first high cycle
  task automatic run_cycle(input bit sel, input int k, input int v,
                           output int hi, output int lo);
    hi = 1;
    for (int n = 0; n < 1000; n++) begin
      trip = (hi - 1 == k);
      @(negedge clk);
      trip = 0;
      if (g(sel)) hi++; else break;
    end
    lo = 1;
    for (int n = 0; n < 1000; n++) begin
      valley = (lo - 1 == v);
      @(negedge clk);
      valley = 0;
      if (!g(sel)) lo++; else break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    chk("R11 gate low in reset", int'(gate), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R11 gate low after reset, disabled", int'(gate), 0);

    en = 1;
    @(negedge clk);
    chk("R10 first pulse without valley", int'(gate), 1);

    for (int i = 0; i < NVEC; i++) begin
      run_cycle(1'b0, VEC[i][0], VEC[i][1], hi, lo);
      chk($sformatf("R2/R1/R3 high time vec %0d", i), hi, VEC[i][2]);
      chk($sformatf("R5/R4/R6/R8 low time vec %0d", i), lo, VEC[i][3]);
    end

    // R9: drop enable mid-pulse
    @(negedge clk);
    en = 0;
    #1 chk("R9 gate low same cycle", int'(gate), 0);
    begin
      int seen = 0;
      for (int n = 0; n < 20; n++) begin
        valley = n[0]; trip = ~n[0];
        @(negedge clk);
        seen |= int'(gate);
      end
      valley = 0; trip = 0;
      chk("R9 pulses ignored while disabled", seen, 0);
    end

    // R10: re-enable, fresh timers
    en = 1;
    @(negedge clk);
    chk("R10 restart pulse on next edge", int'(gate), 1);
    run_cycle(1'b0, NONE, NONE, hi, lo);
    chk("R9 cleared on-timer gives full max on", hi, MAXON);
    chk("R6 timeout after restart", lo, BLANK + TOUT);
    en = 0;

    // R7: clamp instance
    en2 = 1;
    @(negedge clk);
    chk("R10 clamp instance starts", int'(gate2), 1);
    run_cycle(1'b1, 20, NONE, hi, lo);
    chk("R2 clamp instance high", hi, 21);
    chk("R7 off-time clamp", lo, MAXOFF);
    run_cycle(1'b1, 8, 9, hi, lo);
    chk("R7 clamp again after masked valley", lo, MAXOFF);
    en2 = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule